// File: doc/BRIEF.md
# Serial Line Break and Idle Detector

This block watches the level of an asynchronous serial line next to a byte receiver and flags two line conditions without decoding any data. A break is a low level held for at least one full character time. An idle interval is one full character time of continuous high level. The character time is worked out from the configured number of data bits, whether a parity bit is present, the stop-bit length (none, half, one or one and a half bits) and the number of clock cycles per bit.

A break is reported once, on the first high sample after the low run, together with the number of low samples in the run. Idle is reported as a one-cycle pulse each time another full character time of high level has gone by, so a quiet line produces a steady train of pulses. The receiver can re-anchor idle timing when it completes a character. It raises `rx_done` and gives the number of cycles since the character's start edge, and idle time is then counted from the start edge plus one character time rather than from the stop-bit sample.

Top module: `line_cond_detect`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `brk_pulse`, `idle_pulse` and `brk_len` are all zero.
- R2: The character time is ceil(H * C / 2) cycles, where C is `cfg_cycles_per_bit` and H = 2 * (1 + data bits + parity enable) + S. S is the `cfg_stop` code: 0 means no stop bit, 1 a half bit, 2 one bit and 3 one and a half bits.
- R3: `brk_pulse` is high for exactly one cycle, the cycle after the first high sample that ends a run of at least one character time of consecutive low samples. Shorter low runs raise nothing.
- R4: With each break pulse, `brk_len` takes the number of low samples in the run. The count saturates at 2^CNT_W-1, and the value holds until the next break.
- R5: While the line stays high, `idle_pulse` is high for one cycle after every character time of consecutive high samples. Counting restarts from zero after each pulse.
- R6: Any low sample cancels the pending idle count. The next high sample counts as the first of a new interval.
- R7: `rx_done` sampled together with a high line re-anchors idle timing. With E = `rx_elapsed` and F the character time, that sample counts as high sample E+1-F of the interval, which may be zero or negative. A pulse follows at once if this is already F or more.
- R8: `rx_done` sampled together with a low line has no effect. The idle count stays cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the line is sampled on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Serial line level, already synchronised, high when idle |
| cfg_data_bits | input | DB_W | Data bits per character |
| cfg_parity_en | input | 1 | One parity bit per character when high |
| cfg_stop | input | 2 | Stop length code: 0 none, 1 half, 2 one, 3 one and a half |
| cfg_cycles_per_bit | input | CPB_W | Clock cycles per bit, nonzero |
| rx_done | input | 1 | Receiver finished a character in this cycle |
| rx_elapsed | input | CNT_W | Cycles from that character's start edge to this cycle |
| brk_pulse | output | 1 | One-cycle break report |
| brk_len | output | CNT_W | Low-run length of the last break, saturating |
| idle_pulse | output | 1 | One-cycle report per elapsed idle character time |

## Verification
The checks assume that the configuration inputs change only while reset is held and that the cycles-per-bit value is never zero. They also assume that `rx_done` is a single-cycle strobe. The bench loads every configuration inside a reset window and keeps the cycles-per-bit value nonzero. It raises `rx_done` for one cycle at a time, both with the line high and with the line low, and with elapsed values that put the re-anchored count below zero, below the threshold and at or past it.

// File: rtl/brkidle_pkg.sv
package brkidle_pkg;

   typedef enum logic [1:0] {
      STOP_NONE    = 2'd0,
      STOP_HALF    = 2'd1,
      STOP_ONE     = 2'd2,
      STOP_ONEHALF = 2'd3
   } stop_code_e;

   // Half-bit slots contributed by the start bit alone.
   localparam int unsigned START_HALVES = 2;

endpackage

// File: rtl/bid_frame_len.sv
module bid_frame_len
   import brkidle_pkg::*;
#(
   parameter int DB_W    = 4,
   parameter int CPB_W   = 16,
   parameter int CNT_W   = 24,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic [DB_W-1:0]  data_bits,
   input  logic             parity_en,
   input  logic [1:0]       stop,
   input  logic [CPB_W-1:0] cycles_per_bit,
   output logic [CNT_W-1:0] flen
);

   localparam int HW = DB_W + 3;
   localparam int PW = HW + CPB_W;

   logic [HW-1:0]    halves;
   logic [PW-1:0]    prod;
   logic [CNT_W-1:0] flen_c;

   // Character length in half-bit slots, so a half stop bit stays exact.
   always_comb begin
      halves = HW'(START_HALVES)
             + (HW'(data_bits) << 1)
             + (HW'(parity_en) << 1)
             + HW'(stop);
      prod   = PW'(halves) * PW'(cycles_per_bit);
      flen_c = CNT_W'((prod + PW'(1)) >> 1);
   end

   generate
      if (REG_OUT) begin : g_reg
         logic [CNT_W-1:0] flen_q;
         always_ff @(posedge clk) begin
            flen_q <= flen_c;
         end
         assign flen = flen_q;
      end else begin : g_comb
         assign flen = flen_c;
      end
   endgenerate

endmodule

// File: rtl/bid_break_trk.sv
module bid_break_trk #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,
   input  logic [CNT_W-1:0] flen,
   output logic             brk_pulse,
   output logic [CNT_W-1:0] brk_len
);

   localparam logic [CNT_W-1:0] SAT = '1;

   logic [CNT_W-1:0] low_q;
   logic             brk_q;
   logic [CNT_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
         brk_q <= 1'b0;
         len_q <= '0;
      end else if (!line_i) begin
         brk_q <= 1'b0;
         if (low_q != SAT) begin
            low_q <= low_q + CNT_W'(1);
         end
      end else begin
         brk_q <= 1'b0;
         if ((low_q != '0) && (low_q >= flen)) begin
            brk_q <= 1'b1;
            len_q <= low_q;
         end
         low_q <= '0;
      end
   end

   assign brk_pulse = brk_q;
   assign brk_len   = len_q;

endmodule

// File: rtl/bid_idle_trk.sv
module bid_idle_trk #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,
   input  logic [CNT_W-1:0] flen,
   input  logic             rx_done,
   input  logic [CNT_W-1:0] rx_elapsed,
   output logic             idle_pulse
);

   localparam int IW = CNT_W + 2;
   localparam logic signed [IW-1:0] ONE = 1;

   logic signed [IW-1:0] cnt_q;
   logic signed [IW-1:0] nxt;
   logic signed [IW-1:0] flen_s;
   logic signed [IW-1:0] el_s;
   logic                 on_q;
   logic                 pulse_q;

   assign flen_s = $signed({2'b00, flen});
   assign el_s   = $signed({2'b00, rx_elapsed});

   always_comb begin
      if (rx_done) begin
         nxt = el_s + ONE - flen_s;
      end else if (on_q) begin
         nxt = cnt_q + ONE;
      end else begin
         nxt = ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         on_q    <= 1'b0;
         pulse_q <= 1'b0;
      end else if (!line_i) begin
         on_q    <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         on_q <= 1'b1;
         if (nxt >= flen_s) begin
            pulse_q <= 1'b1;
            cnt_q   <= '0;
         end else begin
            pulse_q <= 1'b0;
            cnt_q   <= nxt;
         end
      end
   end

   assign idle_pulse = pulse_q;

endmodule

// File: rtl/line_cond_detect.sv
module line_cond_detect #(
   parameter int DB_W     = 4,
   parameter int CPB_W    = 16,
   parameter int CNT_W    = 24,
   parameter bit REG_FLEN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,
   input  logic [DB_W-1:0]  cfg_data_bits,
   input  logic             cfg_parity_en,
   input  logic [1:0]       cfg_stop,
   input  logic [CPB_W-1:0] cfg_cycles_per_bit,
   input  logic             rx_done,
   input  logic [CNT_W-1:0] rx_elapsed,
   output logic             brk_pulse,
   output logic [CNT_W-1:0] brk_len,
   output logic             idle_pulse
);

   localparam int MIN_CNT_W = DB_W + 3 + CPB_W - 1;

   generate
      if (DB_W < 3) begin : g_bad_db
         $error("line_cond_detect: DB_W must be at least 3");
      end
      if (CPB_W < 1) begin : g_bad_cpb
         $error("line_cond_detect: CPB_W must be at least 1");
      end
      if (CNT_W < MIN_CNT_W) begin : g_bad_cnt
         $error("line_cond_detect: CNT_W too narrow for the character time");
      end
   endgenerate

   logic [CNT_W-1:0] flen;

   bid_frame_len #(
      .DB_W    (DB_W),
      .CPB_W   (CPB_W),
      .CNT_W   (CNT_W),
      .REG_OUT (REG_FLEN)
   ) u_flen (
      .clk            (clk),
      .data_bits      (cfg_data_bits),
      .parity_en      (cfg_parity_en),
      .stop           (cfg_stop),
      .cycles_per_bit (cfg_cycles_per_bit),
      .flen           (flen)
   );

   bid_break_trk #(
      .CNT_W (CNT_W)
   ) u_brk (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (line_i),
      .flen      (flen),
      .brk_pulse (brk_pulse),
      .brk_len   (brk_len)
   );

   bid_idle_trk #(
      .CNT_W (CNT_W)
   ) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line_i),
      .flen       (flen),
      .rx_done    (rx_done),
      .rx_elapsed (rx_elapsed),
      .idle_pulse (idle_pulse)
   );

endmodule

// File: rtl/bid_checker.sv
module bid_checker #(
   parameter int CPB_W = 16,
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_i,
   input logic [CPB_W-1:0] cfg_cycles_per_bit,
   input logic             rx_done,
   input logic [CNT_W-1:0] flen,
   input logic             brk_pulse,
   input logic [CNT_W-1:0] brk_len,
   input logic             idle_pulse
);

   // R2: a nonzero bit time always yields a nonzero character time.
   p_flen_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cycles_per_bit != '0) |-> (flen != '0));

   // R3: a break report follows a low sample and then a high sample.
   p_brk_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |-> ($past(line_i) && !$past(line_i, 2)));

   // R3: a break report lasts one cycle.
   p_brk_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |=> !brk_pulse);

   // R4: a reported run is never shorter than the threshold.
   p_brk_len_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |-> (brk_len >= flen));

   // R4: the reported length holds between reports.
   p_brk_len_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_pulse |-> $stable(brk_len));

   // R5: with a threshold above one and no re-anchor, idle pulses are spaced.
   p_idle_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_pulse && (flen > CNT_W'(1)) && !rx_done) |=> !idle_pulse);

   // R6: an idle report always follows a high sample.
   p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |-> $past(line_i));

endmodule

bind line_cond_detect bid_checker #(
   .CPB_W (CPB_W),
   .CNT_W (CNT_W)
) u_bid_checker (
   .clk                (clk),
   .rst_n              (rst_n),
   .line_i             (line_i),
   .cfg_cycles_per_bit (cfg_cycles_per_bit),
   .rx_done            (rx_done),
   .flen               (flen),
   .brk_pulse          (brk_pulse),
   .brk_len            (brk_len),
   .idle_pulse         (idle_pulse)
);

// File: tb/tb_line_cond_detect.sv
module tb_line_cond_detect;

   localparam int CLK_PERIOD = 10;
   localparam int DB_W  = 4;
   localparam int CPB_W = 6;
   localparam int CNT_W = 12;
   localparam int SATMAX = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             line_i = 1'b1;
   logic [DB_W-1:0]  cfg_data_bits = 4'd8;
   logic             cfg_parity_en = 1'b0;
   logic [1:0]       cfg_stop = 2'd2;
   logic [CPB_W-1:0] cfg_cycles_per_bit = 6'd4;
   logic             rx_done = 1'b0;
   logic [CNT_W-1:0] rx_elapsed = '0;
   logic             brk_pulse;
   logic [CNT_W-1:0] brk_len;
   logic             idle_pulse;

   int checks = 0;
   int failures = 0;
   int brk_seen = 0;
   int idle_seen = 0;

   // Reference model state.
   int  m_low = 0;
   int  m_acc = 0;
   bit  m_on = 0;
   bit  m_brk = 0;
   int  m_len = 0;
   bit  m_idle = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   line_cond_detect #(
      .DB_W  (DB_W),
      .CPB_W (CPB_W),
      .CNT_W (CNT_W)
   ) dut (
      .clk                (clk),
      .rst_n              (rst_n),
      .line_i             (line_i),
      .cfg_data_bits      (cfg_data_bits),
      .cfg_parity_en      (cfg_parity_en),
      .cfg_stop           (cfg_stop),
      .cfg_cycles_per_bit (cfg_cycles_per_bit),
      .rx_done            (rx_done),
      .rx_elapsed         (rx_elapsed),
      .brk_pulse          (brk_pulse),
      .brk_len            (brk_len),
      .idle_pulse         (idle_pulse)
   );

   // R2: character time from the stated half-bit formula.
   function automatic int char_time();
      int h;
      h = 2 * (1 + int'(cfg_data_bits) + int'(cfg_parity_en)) + int'(cfg_stop);
      return (h * int'(cfg_cycles_per_bit) + 1) / 2;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_low = 0; m_acc = 0; m_on = 0; m_brk = 0; m_len = 0; m_idle = 0;
      end else begin
         int f;
         f = char_time();
         m_brk = 0;
         m_idle = 0;
         if (!line_i) begin
            if (m_low < SATMAX) m_low = m_low + 1;
            m_on = 0;
         end else begin
            if (m_low > 0 && m_low >= f) begin
               m_brk = 1;
               m_len = m_low;
            end
            m_low = 0;
            if (rx_done) m_acc = int'(rx_elapsed) + 1 - f;
            else if (m_on) m_acc = m_acc + 1;
            else m_acc = 1;
            m_on = 1;
            if (m_acc >= f) begin
               m_idle = 1;
               m_acc = 0;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the model.
   always @(negedge clk) begin
      if (rst_n) begin
         check(brk_pulse == m_brk, "R3 brk_pulse", int'(brk_pulse), int'(m_brk));
         check(int'(brk_len) == m_len, "R4 brk_len", int'(brk_len), m_len);
         check(idle_pulse == m_idle, "R5 idle_pulse", int'(idle_pulse), int'(m_idle));
         if (brk_pulse) brk_seen++;
         if (idle_pulse) idle_seen++;
      end
   end

   task automatic configure(input int db, input bit par, input int sc, input int cpb);
      @(negedge clk);
      rst_n = 1'b0;
      line_i = 1'b1;
      cfg_data_bits = DB_W'(db);
      cfg_parity_en = par;
      cfg_stop = 2'(sc);
      cfg_cycles_per_bit = CPB_W'(cpb);
      repeat (3) @(negedge clk);
      // R1: outputs quiet under reset.
      check(!brk_pulse && !idle_pulse && brk_len == '0, "R1 reset",
            int'(brk_pulse) + int'(idle_pulse) + int'(brk_len), 0);
      rst_n = 1'b1;
   endtask

   task automatic hold(input bit lvl, input int n);
      line_i = lvl;
      repeat (n) @(negedge clk);
   endtask

   task automatic done_strobe(input bit lvl, input int e);
      line_i = lvl;
      rx_done = 1'b1;
      rx_elapsed = CNT_W'(e);
      @(negedge clk);
      rx_done = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // Config A: 8 data, no parity, one stop, 4 cycles/bit -> 40 (R2).
      configure(8, 1'b0, 2, 4);
      check(!brk_pulse && !idle_pulse, "R1 first cycle after reset",
            int'(brk_pulse) + int'(idle_pulse), 0);
      hold(1, 5);
      brk_seen = 0;
      hold(0, 39); hold(1, 4);
      check(brk_seen == 0, "R3 run one short of 40", brk_seen, 0);
      hold(0, 40); hold(1, 4);
      check(brk_seen == 1, "R3 run of exactly 40", brk_seen, 1);
      check(int'(brk_len) == 40, "R4 length 40", int'(brk_len), 40);
      hold(0, 100); hold(1, 4);
      check(int'(brk_len) == 100, "R4 length 100", int'(brk_len), 100);
      hold(0, 3); idle_seen = 0;
      hold(1, 122);
      check(idle_seen == 3, "R5 three intervals in 122 high", idle_seen, 3);
      hold(1, 30); hold(0, 1); idle_seen = 0;
      hold(1, 39);
      check(idle_seen == 0, "R6 low sample restarts count", idle_seen, 0);
      hold(1, 2);
      check(idle_seen == 1, "R6 pulse after fresh interval", idle_seen, 1);
      // R7: re-anchor with elapsed 45 -> count 6.
      hold(0, 2); hold(1, 10); idle_seen = 0;
      done_strobe(1'b1, 45);
      hold(1, 32);
      check(idle_seen == 0, "R7 anchored count below threshold", idle_seen, 0);
      hold(1, 3);
      check(idle_seen == 1, "R7 anchored pulse", idle_seen, 1);
      // R7: negative start and immediate pulse.
      hold(0, 2); hold(1, 5);
      done_strobe(1'b1, 10);
      hold(1, 90);
      hold(0, 2); hold(1, 3); idle_seen = 0;
      done_strobe(1'b1, 79);
      hold(1, 2);
      check(idle_seen == 1, "R7 anchor at threshold pulses at once", idle_seen, 1);
      // R8: strobe with low line ignored.
      hold(0, 3); idle_seen = 0;
      done_strobe(1'b0, 79);
      hold(0, 2); hold(1, 30);
      check(idle_seen == 0, "R8 strobe during low ignored", idle_seen, 0);
      hold(1, 20);

      // Config B: 5 data, parity, half stop, 3 cycles/bit -> 23 (R2).
      configure(5, 1'b1, 1, 3);
      hold(1, 5); brk_seen = 0;
      hold(0, 22); hold(1, 4);
      check(brk_seen == 0, "R2 half stop run 22", brk_seen, 0);
      hold(0, 23); hold(1, 4);
      check(brk_seen == 1 && int'(brk_len) == 23, "R2 half stop run 23", int'(brk_len), 23);
      hold(1, 60);

      // Config C: 9 data, parity, 1.5 stop, 5 cycles/bit -> 63 (R2).
      configure(9, 1'b1, 3, 5);
      hold(1, 5); brk_seen = 0;
      hold(0, 62); hold(1, 4);
      check(brk_seen == 0, "R2 one-and-half stop run 62", brk_seen, 0);
      hold(0, 63); hold(1, 4);
      check(brk_seen == 1 && int'(brk_len) == 63, "R2 one-and-half stop run 63", int'(brk_len), 63);
      hold(1, 140);

      // Config D: 7 data, no parity, no stop, 1 cycle/bit -> 8 (R2).
      configure(7, 1'b0, 0, 1);
      hold(0, 2); idle_seen = 0;
      hold(1, 18);
      check(idle_seen == 2, "R5 no-stop interval 8", idle_seen, 2);
      hold(0, 7); hold(1, 3); hold(0, 8); hold(1, 3);

      // Config E: saturation, 9 data, parity, 1.5 stop, 63 cycles/bit -> 788.
      configure(9, 1'b1, 3, 63);
      hold(1, 3);
      hold(0, 4200); hold(1, 4);
      check(int'(brk_len) == SATMAX, "R4 saturated length", int'(brk_len), SATMAX);
      hold(1, 10);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule